// File: doc/BRIEF.md
# Keyed Diagnostic Register Guard

This block keeps a host diagnostic control register closed until software proves intent. Software must first write a fixed series of four key values to a dedicated key register. Once that series has arrived in order, the diagnostic register accepts writes. Writes sent to it at any other time are silently discarded. The register holds the diagnostic enables and a request bit for an adapter reset. When that request bit is written, the block emits a one-cycle reset pulse, records the event in a sticky history bit and locks the register again.

The host reaches the block through a simple 32-bit register port: a valid strobe, a write flag, a byte offset and write data. Read data comes back combinationally for the offset being presented. The block does not carry out the reset itself. It only raises `adapter_reset_o` for the logic that does.

Top module: `diag_key_guard`

## Requirements
- R1: After reset the diagnostic register (offset 0x08) reads 0, `unlocked_o`, `adapter_reset_o` and all enable outputs are low.
- R2: Writing the 32-bit values 0x04, 0x02, 0x07, 0x0D in that order to the key register at offset 0x08-4 (0x04) unlocks the diagnostic register; while unlocked, diagnostic bit 7 reads 1 and `unlocked_o` is high.
- R3: A key write whose value is not the expected next key restarts the tracker: it counts as the first key if it equals 0x04, otherwise the tracker returns to its start.
- R4: Any key write made while unlocked locks the register again and is then tracked as a fresh first write.
- R5: While locked, writes to offset 0x08 change no stored bit and reads still return the current value.
- R6: While unlocked, a write to offset 0x08 stores bit 0 (diagnostic memory enable, `diag_mem_en_o`), bit 1 (embedded processor halt, `cpu_halt_o`), bit 4 (diagnostic read/write enable, `diag_rw_en_o`) and bit 9 (boot hold, `boot_hold_o`), and the register stays unlocked unless bit 2 is set.
- R7: A write with bit 2 set while unlocked raises `adapter_reset_o` for exactly one cycle starting the cycle after the write, sets sticky history bit 5 and relocks; bit 2 always reads 0.
- R8: `flash_bad_i` high sets sticky bit 6; writing 1 to bit 10 while unlocked clears it unless `flash_bad_i` is high in the same cycle; bit 10 reads 0 and locked writes of bit 10 have no effect.
- R9: Bit 7 cannot be written; the key register and all other offsets read 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `req_addr_i` (combinational) |
| flash_bad_i | input | 1 | Sets the bad flash signature flag |
| adapter_reset_o | output | 1 | One-cycle adapter reset request |
| diag_mem_en_o | output | 1 | Diagnostic memory enable |
| cpu_halt_o | output | 1 | Embedded processor halt |
| diag_rw_en_o | output | 1 | Diagnostic read/write enable |
| boot_hold_o | output | 1 | Prevents controller boot |
| unlocked_o | output | 1 | Diagnostic register currently writable |

## Verification
Every stored bit and the lock state update on the clock edge that accepts the write. Read data is combinational, so the new value is visible in the half-cycle that follows that edge. The bench drives on the falling edge and samples on the next falling edge. The reset pulse is registered from the accepted write. It is therefore checked high at the first falling edge after the write and low one cycle later. A sweep runs every byte value in each key position and compares lock state and readback against a sequence model kept in the bench.

// File: rtl/diag_guard_pkg.sv
package diag_guard_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int KEY_LEN = 4;
  localparam logic [KEY_LEN-1:0][7:0] KEY_SEQ = {8'h0D, 8'h07, 8'h02, 8'h04};

  localparam logic [ADDR_W-1:0] KEY_OFF  = 8'h04;
  localparam logic [ADDR_W-1:0] DIAG_OFF = 8'h08;

  localparam int B_MEM_EN = 0;
  localparam int B_HALT   = 1;
  localparam int B_RESET  = 2;
  localparam int B_RW_EN  = 4;
  localparam int B_HIST   = 5;
  localparam int B_BAD    = 6;
  localparam int B_OPEN   = 7;
  localparam int B_BOOT   = 9;
  localparam int B_CLRBAD = 10;

  typedef struct packed {
    logic boot_hold;
    logic rw_en;
    logic cpu_halt;
    logic mem_en;
  } diag_ctrl_t;
endpackage

// File: rtl/diag_key_tracker.sv
module diag_key_tracker #(
  parameter int DATA_W  = 32,
  parameter int KEY_LEN = 4,
  parameter logic [KEY_LEN-1:0][7:0] KEYS = diag_guard_pkg::KEY_SEQ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [DATA_W-1:0] key_data_i,
  input  logic              relock_i,
  output logic              unlocked_o
);
  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic             open_q;
  logic             hit, first_hit, at_last;

  assign hit       = key_data_i == DATA_W'(KEYS[idx_q]);
  assign first_hit = key_data_i == DATA_W'(KEYS[0]);
  assign at_last   = idx_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      open_q <= 1'b0;
    end else if (key_we_i) begin
      open_q <= hit && at_last;
      if (hit) idx_q <= at_last ? '0 : idx_q + 1'b1;
      else     idx_q <= first_hit ? IDX_W'(1 % KEY_LEN) : '0;
    end else if (relock_i) begin
      open_q <= 1'b0;
    end
  end

  assign unlocked_o = open_q;

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
  assert_mismatch_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && !hit) |=> !open_q);
  assert_key_write_relocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && !at_last) |=> !open_q);
endmodule

// File: rtl/diag_ctrl_reg.sv
module diag_ctrl_reg
  import diag_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              unlocked_i,
  input  logic              flash_bad_i,
  output diag_ctrl_t        ctrl_o,
  output logic              hist_o,
  output logic              bad_o,
  output logic              reset_req_o,
  output logic              relock_o
);
  diag_ctrl_t ctrl_q;
  logic       hist_q, bad_q, pulse_q;
  logic       wr_ok;

  assign wr_ok    = we_i && unlocked_i;
  assign relock_o = wr_ok && wdata_i[B_RESET];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      hist_q  <= 1'b0;
      bad_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= relock_o;
      if (relock_o) hist_q <= 1'b1;
      if (wr_ok) begin
        ctrl_q.mem_en    <= wdata_i[B_MEM_EN];
        ctrl_q.cpu_halt  <= wdata_i[B_HALT];
        ctrl_q.rw_en     <= wdata_i[B_RW_EN];
        ctrl_q.boot_hold <= wdata_i[B_BOOT];
      end
      if (flash_bad_i)                      bad_q <= 1'b1;
      else if (wr_ok && wdata_i[B_CLRBAD]) bad_q <= 1'b0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign hist_o      = hist_q;
  assign bad_o       = bad_q;
  assign reset_req_o = pulse_q;

  assert_locked_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked_i) |=> $stable(ctrl_q));
  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  assert_history_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> hist_q);
  assert_bad_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_q && !wr_ok) |=> bad_q);
endmodule

// File: rtl/diag_key_guard.sv
module diag_key_guard
  import diag_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              flash_bad_i,
  output logic              adapter_reset_o,
  output logic              diag_mem_en_o,
  output logic              cpu_halt_o,
  output logic              diag_rw_en_o,
  output logic              boot_hold_o,
  output logic              unlocked_o
);
  logic       key_we, diag_we, unlocked, relock, hist, bad, rst_pulse;
  diag_ctrl_t ctrl;
  logic [DATA_W-1:0] diag_view;

  assign key_we  = req_valid_i && req_write_i && (req_addr_i == KEY_OFF);
  assign diag_we = req_valid_i && req_write_i && (req_addr_i == DIAG_OFF);

  diag_key_tracker #(.DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .KEYS(KEY_SEQ)) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_we_i   (key_we),
    .key_data_i (req_wdata_i),
    .relock_i   (relock),
    .unlocked_o (unlocked)
  );

  diag_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (diag_we),
    .wdata_i     (req_wdata_i),
    .unlocked_i  (unlocked),
    .flash_bad_i (flash_bad_i),
    .ctrl_o      (ctrl),
    .hist_o      (hist),
    .bad_o       (bad),
    .reset_req_o (rst_pulse),
    .relock_o    (relock)
  );

  always_comb begin
    diag_view           = '0;
    diag_view[B_MEM_EN] = ctrl.mem_en;
    diag_view[B_HALT]   = ctrl.cpu_halt;
    diag_view[B_RW_EN]  = ctrl.rw_en;
    diag_view[B_HIST]   = hist;
    diag_view[B_BAD]    = bad;
    diag_view[B_OPEN]   = unlocked;
    diag_view[B_BOOT]   = ctrl.boot_hold;
  end

  assign rd_data_o       = (req_addr_i == DIAG_OFF) ? diag_view : '0;
  assign adapter_reset_o = rst_pulse;
  assign diag_mem_en_o   = ctrl.mem_en;
  assign cpu_halt_o      = ctrl.cpu_halt;
  assign diag_rw_en_o    = ctrl.rw_en;
  assign boot_hold_o     = ctrl.boot_hold;
  assign unlocked_o      = unlocked;

  assert_reset_relocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapter_reset_o |-> !unlocked_o);
  assert_unlocked_write_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_we && unlocked && !req_wdata_i[B_RESET]) |=> unlocked_o);
endmodule

// File: tb/diag_key_guard_test.sv
module diag_key_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, fbad = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, mem_en, halt, rw_en, boot, unl;

  int errors = 0, checks = 0;
  int idx_m = 0;
  bit unl_m = 0;
  logic [7:0] keys [4] = '{8'h04, 8'h02, 8'h07, 8'h0D};

  always #10 clk = ~clk;

  diag_key_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rd_data_o(rdata), .flash_bad_i(fbad),
    .adapter_reset_o(rst_req), .diag_mem_en_o(mem_en), .cpu_halt_o(halt),
    .diag_rw_en_o(rw_en), .boot_hold_o(boot), .unlocked_o(unl));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; addr = 8'h08;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; valid = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    valid = 1'b0; addr = 8'h08;
  endtask

  // Sequence model from R2/R3/R4
  task automatic mdl_key(input logic [31:0] v);
    if (v == 32'(keys[idx_m])) begin
      unl_m = (idx_m == 3);
      idx_m = (idx_m == 3) ? 0 : idx_m + 1;
    end else begin
      unl_m = 0;
      idx_m = (v == 32'h04) ? 1 : 0;
    end
  endtask

  task automatic unlock();
    for (int j = 0; j < 4; j++) wr(8'h04, 32'(keys[j]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    addr = 8'h08;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(8'h08, r);
    chk("R1 diag reset", r, 32'h0);
    chk("R1 outputs", {27'b0, rst_req, mem_en, halt, rw_en, boot, unl} , 32'h0);

    // R2/R3/R4/R5 sweep over every byte in every key slot
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        wr(8'h04, 32'hFF); mdl_key(32'hFF);
        for (int j = 0; j < 4; j++) begin
          logic [31:0] kv;
          kv = (j == p) ? 32'(v) : 32'(keys[j]);
          wr(8'h04, kv); mdl_key(kv);
        end
        wr(8'h08, 32'h11);
        rd(8'h08, r);
        chk("R3 sweep readback", r, unl_m ? 32'h91 : 32'h0);
        chk("R2 sweep unlocked_o", {31'b0, unl}, {31'b0, unl_m});
        wr(8'h08, 32'h0);
      end
    end

    // R3: repeated first key restarts
    wr(8'h04, 32'hFF);
    wr(8'h04, 32'h04); wr(8'h04, 32'h04); wr(8'h04, 32'h02);
    wr(8'h04, 32'h07); wr(8'h04, 32'h0D);
    chk("R3 restart on first key", {31'b0, unl}, 32'h1);

    // R4: key write while unlocked relocks
    wr(8'h04, 32'h04);
    chk("R4 relock on key write", {31'b0, unl}, 32'h0);
    wr(8'h04, 32'h02); wr(8'h04, 32'h07); wr(8'h04, 32'h0D);
    chk("R4 tracked as fresh start", {31'b0, unl}, 32'h1);

    // R6 store all control bits, R9 bit7 not writable
    wr(8'h08, 32'h0000_0213 | 32'h80);
    rd(8'h08, r);
    chk("R6 ctrl bits stored", r, 32'h293);
    chk("R6 ctrl outputs", {28'b0, mem_en, halt, rw_en, boot}, 32'hF);
    wr(8'h08, 32'h0);
    rd(8'h08, r);
    chk("R9 bit7 read-only", r, 32'h80);

    // R9 other offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, r);
    chk("R9 other offset write no effect", r, 32'h80);
    rd(8'h04, r);
    chk("R9 key register reads 0", r, 32'h0);
    rd(8'h10, r);
    chk("R9 other offset reads 0", r, 32'h0);

    // R5 locked drop
    wr(8'h04, 32'hFF);
    wr(8'h08, 32'h213);
    rd(8'h08, r);
    chk("R5 locked write dropped", r, 32'h0);
    chk("R5 no reset when locked", {31'b0, rst_req}, 32'h0);

    // R7 reset request
    unlock();
    wr(8'h08, 32'h15);
    chk("R7 pulse high", {31'b0, rst_req}, 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, rst_req}, 32'h0);
    rd(8'h08, r);
    chk("R7 history set, relocked, bit2 zero", r, 32'h31);
    wr(8'h08, 32'h0);
    rd(8'h08, r);
    chk("R7 relocked drops write", r, 32'h31);

    // R8 flash bad flag
    @(negedge clk); fbad = 1'b1;
    @(negedge clk); fbad = 1'b0;
    rd(8'h08, r);
    chk("R8 bad flag set", r, 32'h71);
    wr(8'h08, 32'h400);
    rd(8'h08, r);
    chk("R8 locked clear ignored", r, 32'h71);
    unlock();
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = 8'h08; wdata = 32'h401; fbad = 1'b1;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; fbad = 1'b0;
    rd(8'h08, r);
    chk("R8 set wins over clear", r, 32'hE1);
    wr(8'h08, 32'h401);
    rd(8'h08, r);
    chk("R8 clear while unlocked", r, 32'hA1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule